// File: doc/BRIEF.md
# Serial Byte FIFO Pair with Threshold Interrupts

This block holds the two byte queues that sit between a register-mapped host and a serial shift engine. The transmit queue is filled by host register writes and drained by the engine. The receive queue is filled by the engine and drained by host register reads. Each queue has its own enable and its own programmable threshold. A single interrupt line summarises a small set of event and level sources.

The host sees seven word registers through a write strobe and a read strobe. Read data is returned the cycle after the read strobe.

| Index | Register | Contents |
|---|---|---|
| 0 | control | bit 0 receive enable, bit 1 transmit enable, bits 10:4 receive threshold, bits 22:16 transmit threshold |
| 1 | idle limit | 4 bits |
| 2 | interrupt mask | bits 6:0 |
| 3 | interrupt status | bits 6:0, write-one-to-clear |
| 4 | occupancy word | read only |
| 5 | transmit data | write pushes a byte |
| 6 | receive data | read pops a byte |

The two data-facing sides are timed as follows:
- The engine pops a transmit byte with a one-cycle strobe, and the byte appears on its data output one cycle later.
- The engine pushes a receive byte with a one-cycle strobe.

When a receive transfer ends with fewer bytes buffered than the threshold, an idle-time source lets the host collect the leftover bytes. It fires after a programmable number of cycles without a push.

Top module: `sfp_fifo_pair`

## Requirements
- R1: After reset the occupancy word reads 0x01000100 (both queues empty), the interrupt status reads 0 and `irq` is low.
- R2: Bytes written to index 5 leave on `eng_tx_data` in write order. Each byte is valid in the cycle after the `eng_tx_pop` strobe.
- R3: Bytes pushed with `eng_rx_push` are returned in push order by reads of index 6.
- R4: The occupancy word is laid out as follows, and a level never exceeds DEPTH:
  - bits 6:0: transmit level
  - bit 7: transmit full
  - bit 8: transmit empty
  - bits 22:16: receive level
  - bit 23: receive full
  - bit 24: receive empty
- R5: A push into a full queue is dropped and leaves the level at DEPTH. It sets status bit 3 for transmit or bit 5 for receive.
- R6: A pop from an empty enabled queue returns zero and sets status bit 2 for transmit or bit 4 for receive.
- R7: Status bit 0 is set while transmit is enabled and its level is at or below the transmit threshold.
- R8: Status bit 1 is set while receive is enabled and its level is at or above the receive threshold.
- R9: Status bit 6 is set once the receive queue has been non-empty and below its threshold for the programmed idle limit of cycles without a push.
- R10: Writing index 3 clears exactly the status bits written as one. Bits written as zero keep their value, and a level source that still holds sets its bit again.
- R11: `irq` equals the OR of status ANDed with mask, one cycle later.
- R12: A disabled queue is held empty: its pushes are ignored and it sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Transmit byte, valid the cycle after the pop |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_data | input | 8 | Receive byte |
| irq | output | 1 | Masked interrupt request |

## Verification
The bound checker watches, on every cycle, the following properties:
- the bounds of both levels;
- the emptiness of a disabled queue;
- a full receive queue keeping its level through a dropped push;
- the zero byte returned on a transmit underrun;
- the one-cycle relation between masked status and `irq`.

Only the bench scenarios can show the ordering of bytes through each queue and the exact bit positions of the register fields. The same holds for write-one-to-clear acting on chosen bits only and for the idle-limit source firing late rather than early.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int ADDR_W  = 3;
  localparam int LVL_W   = 7;
  localparam int IDLE_W  = 4;
  localparam int NUM_SRC = 7;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_IDLE  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_OCC   = 3'd4;
  localparam logic [ADDR_W-1:0] RA_TXD   = 3'd5;
  localparam logic [ADDR_W-1:0] RA_RXD   = 3'd6;

  localparam int SB_TX_LOW  = 0;
  localparam int SB_RX_HIGH = 1;
  localparam int SB_TX_UDF  = 2;
  localparam int SB_TX_OVF  = 3;
  localparam int SB_RX_UDF  = 4;
  localparam int SB_RX_OVF  = 5;
  localparam int SB_RX_IDLE = 6;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             udf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             push_ok, pop_ok;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign ovf     = push && full;
  assign udf     = pop && empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (pop) begin
      dout <= pop_ok ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end
endmodule

// File: rtl/sfp_idle_timer.sv
module sfp_idle_timer #(
  parameter int LVL_W  = 7,
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  thresh,
  input  logic              push,
  input  logic [IDLE_W-1:0] limit,
  output logic              fire
);
  logic [IDLE_W-1:0] cnt;
  logic              partial;

  assign partial = (level != '0) && (level < thresh);
  assign fire    = partial && !push && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !partial || push) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfp_irq_ctrl.sv
module sfp_irq_ctrl #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] keep;

  assign keep = clr_we ? ~clr_bits : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & keep) | set;
      irq  <= |(stat & mask);
    end
  end
endmodule

// File: rtl/sfp_fifo_pair.sv
module sfp_fifo_pair
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  output logic              irq
);
  logic              rx_en, tx_en;
  logic [LVL_W-1:0]  rx_thr, tx_thr;
  logic [IDLE_W-1:0] idle_lim;
  logic [NUM_SRC-1:0] mask, stat, set;

  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovf, tx_udf, rx_ovf, rx_udf, idle_fire;
  logic [7:0]        rx_dout;
  logic [31:0]       rd_q, occ_word;
  logic              rd_rx_q;
  logic              wd_unused;

  assign wd_unused = ^{reg_wdata[31:23], reg_wdata[15:11], reg_wdata[3:2]};

  assign tx_push = reg_wr && (reg_addr == RA_TXD) && tx_en;
  assign tx_pop  = eng_tx_pop && tx_en;
  assign rx_push = eng_rx_push && rx_en;
  assign rx_pop  = reg_rd && (reg_addr == RA_RXD) && rx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      rx_thr   <= '0;
      tx_thr   <= '0;
      idle_lim <= '0;
      mask     <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          rx_en  <= reg_wdata[0];
          tx_en  <= reg_wdata[1];
          rx_thr <= reg_wdata[10:4];
          tx_thr <= reg_wdata[22:16];
        end
        RA_IDLE: idle_lim <= reg_wdata[IDLE_W-1:0];
        RA_MASK: mask     <= reg_wdata[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  sfp_fifo #(.DEPTH(DEPTH), .DW(8), .LVL_W(LVL_W)) u_txq (
    .clk(clk), .rst(rst), .clr(!tx_en), .push(tx_push), .din(reg_wdata[7:0]),
    .pop(tx_pop), .dout(eng_tx_data), .level(tx_level), .full(tx_full),
    .empty(tx_empty), .ovf(tx_ovf), .udf(tx_udf)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DW(8), .LVL_W(LVL_W)) u_rxq (
    .clk(clk), .rst(rst), .clr(!rx_en), .push(rx_push), .din(eng_rx_data),
    .pop(rx_pop), .dout(rx_dout), .level(rx_level), .full(rx_full),
    .empty(rx_empty), .ovf(rx_ovf), .udf(rx_udf)
  );

  sfp_idle_timer #(.LVL_W(LVL_W), .IDLE_W(IDLE_W)) u_idle (
    .clk(clk), .rst(rst), .level(rx_level), .thresh(rx_thr),
    .push(rx_push), .limit(idle_lim), .fire(idle_fire)
  );

  always_comb begin
    set             = '0;
    set[SB_TX_LOW]  = tx_en && (tx_level <= tx_thr);
    set[SB_RX_HIGH] = rx_en && (rx_level >= rx_thr);
    set[SB_TX_UDF]  = tx_udf;
    set[SB_TX_OVF]  = tx_ovf;
    set[SB_RX_UDF]  = rx_udf;
    set[SB_RX_OVF]  = rx_ovf;
    set[SB_RX_IDLE] = rx_en && idle_fire;
  end

  sfp_irq_ctrl #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .set(set),
    .clr_we(reg_wr && (reg_addr == RA_STAT)), .clr_bits(reg_wdata[NUM_SRC-1:0]),
    .mask(mask), .stat(stat), .irq(irq)
  );

  assign occ_word = {7'b0, rx_empty, rx_full, rx_level,
                     7'b0, tx_empty, tx_full, tx_level};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= '0;
      rd_rx_q <= 1'b0;
    end else begin
      rd_rx_q <= rx_pop;
      rd_q    <= '0;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL: rd_q <= {9'b0, tx_thr, 5'b0, rx_thr, 2'b0, tx_en, rx_en};
          RA_IDLE: rd_q <= 32'(idle_lim);
          RA_MASK: rd_q <= 32'(mask);
          RA_STAT: rd_q <= 32'(stat);
          RA_OCC:  rd_q <= occ_word;
          default: rd_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rd_rx_q ? {24'b0, rx_dout} : rd_q;
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 7,
  parameter int N     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             rx_en,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             eng_tx_pop,
  input logic [7:0]       eng_tx_data,
  input logic             eng_rx_push,
  input logic             rx_pop,
  input logic [N-1:0]     stat,
  input logic [N-1:0]     mask,
  input logic             irq
);
  a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

  a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_en && eng_rx_push && !rx_pop && rx_level == LVL_W'(DEPTH))
      |=> (rx_level == LVL_W'(DEPTH)));

  a_r6_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_en && eng_tx_pop && tx_level == '0) |=> (eng_tx_data == 8'h00));

  a_r11_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(stat & mask))));

  a_r12_tx_held_empty: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (tx_level == '0));

  a_r12_rx_held_empty: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (rx_level == '0));
endmodule

bind sfp_fifo_pair sfp_checker #(.DEPTH(DEPTH), .LVL_W(sfp_pkg::LVL_W), .N(sfp_pkg::NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
  .tx_level(tx_level), .rx_level(rx_level),
  .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
  .eng_rx_push(eng_rx_push), .rx_pop(rx_pop),
  .stat(stat), .mask(mask), .irq(irq)
);

// File: tb/tb_sfp_fifo_pair.sv
module tb_sfp_fifo_pair;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [31:0] rv;

  always #4 clk = ~clk;

  sfp_fifo_pair #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // driver: host write to transmit data, expected byte queued
  task automatic tx_put(input logic [7:0] b);
    wr(3'd5, {24'b0, b});
    txq.push_back(b);
  endtask

  // monitor: engine pop, compare with scoreboard head
  task automatic tx_take(input string req);
    logic [7:0] e;
    @(negedge clk); eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0;
    e = (txq.size() > 0) ? txq.pop_front() : 8'h00;
    chk(req, {24'b0, eng_tx_data}, {24'b0, e});
  endtask

  task automatic rx_put(input logic [7:0] b, input bit expect_kept);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk); eng_rx_push = 1'b0;
    if (expect_kept) rxq.push_back(b);
  endtask

  task automatic rx_take(input string req);
    logic [7:0] e;
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
    rd(3'd6, rv);
    chk(req, rv, {24'b0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(3'd4, rv); chk("R1 occupancy", rv, 32'h0100_0100);
    rd(3'd3, rv); chk("R1 status", rv, 32'h0);

    // enable both, rx threshold 4, tx threshold 2
    wr(3'd0, 32'h0002_0043);
    rd(3'd0, rv); chk("R4 control readback", rv, 32'h0002_0043);
    rd(3'd3, rv); chk("R7 tx low at empty", rv & 32'h1, 32'h1);

    for (int i = 0; i < DEPTH; i++) tx_put(8'h10 + 8'(i * 7));
    rd(3'd4, rv); chk("R4 tx full word", rv, 32'h0100_0090);
    wr(3'd3, 32'h7F);
    rd(3'd3, rv); chk("R10 clear all, R7 low above threshold", rv, 32'h0);

    // overrun on transmit
    wr(3'd5, 32'hEE);
    rd(3'd4, rv); chk("R5 tx level kept", rv & 32'h1FF, 32'h090);
    rd(3'd3, rv); chk("R5 tx overrun bit3", rv, 32'h08);
    wr(3'd3, 32'h04);
    rd(3'd3, rv); chk("R10 zero bits keep value", rv, 32'h08);
    wr(3'd3, 32'h08);
    rd(3'd3, rv); chk("R10 one bit clears", rv, 32'h0);

    for (int i = 0; i < DEPTH; i++) tx_take("R2 tx order");
    rd(3'd3, rv); chk("R7 tx low after drain", rv & 32'h1, 32'h1);
    wr(3'd3, 32'h01);
    rd(3'd3, rv); chk("R10 level source re-sets", rv & 32'h1, 32'h1);

    // underrun on transmit
    tx_take("R6 tx underrun data zero");
    rd(3'd3, rv); chk("R6 tx underrun bit2", rv & 32'h4, 32'h4);
    wr(3'd2, 32'h04);
    repeat (2) @(negedge clk);
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h04);
    repeat (2) @(negedge clk);
    chk("R11 irq low after clear", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h00);

    // receive: idle limit 3
    wr(3'd1, 32'h3);
    wr(3'd3, 32'h7F);
    rx_put(8'hA1, 1'b1);
    rd(3'd3, rv); chk("R9 idle not yet", rv & 32'h40, 32'h0);
    repeat (8) @(negedge clk);
    rd(3'd3, rv); chk("R9 idle fired", rv & 32'h40, 32'h40);
    rd(3'd3, rv); chk("R8 below threshold", rv & 32'h2, 32'h0);
    rx_put(8'hA2, 1'b1); rx_put(8'h5B, 1'b1); rx_put(8'h00, 1'b1);
    rd(3'd3, rv); chk("R8 at threshold", rv & 32'h2, 32'h2);
    for (int i = 0; i < 4; i++) rx_take("R3 rx order");
    rx_take("R6 rx underrun data zero");
    rd(3'd3, rv); chk("R6 rx underrun bit4", rv & 32'h10, 32'h10);

    for (int i = 0; i < DEPTH; i++) rx_put(8'hC0 ^ 8'(i * 3), 1'b1);
    rx_put(8'h77, 1'b0);
    rd(3'd4, rv); chk("R4 rx full word", rv & 32'h01FF_0000, 32'h0090_0000);
    rd(3'd3, rv); chk("R5 rx overrun bit5", rv & 32'h20, 32'h20);
    for (int i = 0; i < DEPTH; i++) rx_take("R3 rx order full");

    // disabled queues
    tx_put(8'h33); txq.delete();
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h7F);
    wr(3'd5, 32'h44);
    rx_put(8'h55, 1'b0);
    rd(3'd4, rv); chk("R12 disabled occupancy", rv, 32'h0100_0100);
    rd(3'd3, rv); chk("R12 disabled no status", rv, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule